// File: doc/BRIEF.md
# Byte-Parity SRAM Guard with Page Lock

This block sits in front of a single-port 32-bit on-chip SRAM and keeps one even-parity bit per byte lane next to the data, so each stored word is 36 bits. Every accepted write computes parity for the lanes it touches. Every accepted read checks the lanes it requests. A mismatch raises a one-cycle interrupt request and sets a sticky error flag. A control bit can also copy the interrupt to a timer break output. Host accesses take byte, half-word or word form through a 4-bit byte-enable field, and are served with no wait states. Read data and the response come back in the cycle after the request.

A page-lock register holds one bit per page of `PAGE_WORDS` words. The default of 256 words makes a 1 KB page. Software can only set these bits, and only reset clears them. A write that lands on a locked page is dropped and answered with an error response.

A sweep engine clears the whole array to zero words with valid parity. It has three states:
- `ST_BOOT` is entered on reset. It moves to `ST_SWEEP` when the erase-at-reset option input is high, and to `ST_IDLE` otherwise.
- `ST_IDLE` moves to `ST_SWEEP` when software writes the erase bit.
- `ST_SWEEP` writes one word per cycle and returns to `ST_IDLE` after the last word.

Outside `ST_IDLE`, `host_ready` is low and host requests are ignored.

Top module: `sram_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block is in `ST_BOOT`: `erase_busy`=1, `host_ready`=0, `wp_status`=0, `par_err_flag`=0, `nmi_pulse`=0, `brk_out`=0, `rsp_valid`=0.
- R2: A request accepted in cycle T (`req`=1 and `host_ready`=1) gives `rsp_valid`=1 in cycle T+1. For a read, `rdata` in T+1 holds the full 32-bit stored word at word address `addr`. Lane i is bits [8i+7:8i].
- R3: A write stores only the lanes whose `be[i]`=1, together with an even parity bit for each of those lanes. Unwritten lanes keep their data and their parity.
- R4: While control bit 3 (parity invert) is set, written lanes store inverted parity. A later checked read of such a lane reports an error.
- R5: A read checks only the lanes selected by its `be`. A bad lane outside `be` raises no error.
- R6: A parity error drives `nmi_pulse` high for exactly the response cycle of the failing read, when `opt_parity_en`=1 and `rsp_err`=0.
- R7: `par_err_flag` goes high in the cycle after `nmi_pulse` and stays high. A control write with bit 2 set clears it. A new error in the same cycle wins over the clear.
- R8: `brk_out` equals `nmi_pulse` while control bit 1 (break routing) is set, and stays 0 otherwise.
- R9: With `opt_parity_en`=0, reads never raise `nmi_pulse` or set the flag.
- R10: A write with `cfg_sel`=0 ORs `cfg_wdata` into `wp_status`. Zero bits have no effect, and only reset clears bits. The page of word address `addr` is its top log2(`NUM_PAGES`) bits.
- R11: A write to a locked page leaves memory unchanged and gives `rsp_err`=1 with `rsp_valid`=1. Reads of locked pages behave normally.
- R12: A control write (`cfg_sel`=1) with bit 0 set in `ST_IDLE` enters `ST_SWEEP`. That state lasts exactly DEPTH cycles, with `erase_busy`=1 and `host_ready`=0, and all words end as zero with valid parity. Requests during the sweep get no response and write nothing.
- R13: With `opt_erase_on_reset`=1 at reset release, `erase_busy` stays high for 1+DEPTH cycles. With it low, `erase_busy` stays high for 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_parity_en | input | 1 | Static option: enable read parity checking |
| opt_erase_on_reset | input | 1 | Static option: sweep the array after reset |
| req | input | 1 | Host access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | IDX_W | Word address |
| be | input | 4 | Byte-lane enables |
| wdata | input | 32 | Write data |
| host_ready | output | 1 | High when requests are accepted |
| rsp_valid | output | 1 | Response cycle of an accepted request |
| rsp_err | output | 1 | Write was refused (locked page) |
| rdata | output | 32 | Read data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = page-lock register, 1 = control |
| cfg_wdata | input | NUM_PAGES | Configuration write data |
| wp_status | output | NUM_PAGES | Page-lock bits |
| erase_busy | output | 1 | Sweep engine not idle |
| par_err_flag | output | 1 | Sticky parity error flag |
| nmi_pulse | output | 1 | One-cycle parity error interrupt |
| brk_out | output | 1 | Parity error routed to timer break |

## Verification
The bench builds the block with `PAGE_WORDS`=4 and `NUM_PAGES`=8. This gives a 32-word array with 5-bit addresses. A full sweep then takes 32 cycles, so both erase paths can be timed exactly, and writes can hit several distinct pages, locked and unlocked, within a few addresses. The parity-invert control bit is what makes single-lane corruption reachable, so the lane-selective checking, the break routing and the disabled-check option can each be exercised against one planted bad lane.

// File: rtl/sram_guard_pkg.sv
package sram_guard_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int WORD_W = DATA_W + LANES;

    // control register bit positions
    localparam int CTL_ERASE   = 0;
    localparam int CTL_BRK     = 1;
    localparam int CTL_CLRFLAG = 2;
    localparam int CTL_INVPAR  = 3;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SWEEP = 2'd2
    } sweep_state_e;

endpackage

// File: rtl/sram_guard_parity.sv
module sram_guard_parity
    import sram_guard_pkg::*;
(
    input  logic [DATA_W-1:0] wr_data,
    input  logic              invert,
    input  logic [WORD_W-1:0] rd_word,
    output logic [LANES-1:0]  wr_par,
    output logic [LANES-1:0]  lane_bad
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // even parity: stored bit makes the 9-bit group have an even count of ones
        assign wr_par[g]   = (^wr_data[g*LANE_W +: LANE_W]) ^ invert;
        assign lane_bad[g] = (^rd_word[g*LANE_W +: LANE_W]) ^ rd_word[DATA_W + g];
    end

endmodule

// File: rtl/sram_guard_mem.sv
module sram_guard_mem
    import sram_guard_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] array_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lanes[i]) begin
                    array_q[wr_idx][i*LANE_W +: LANE_W] <= wr_word[i*LANE_W +: LANE_W];
                    array_q[wr_idx][DATA_W + i]         <= wr_word[DATA_W + i];
                end
            end
        end
        if (rd_en) begin
            rd_word <= array_q[rd_idx];
        end
    end

endmodule

// File: rtl/sram_guard_lock.sv
module sram_guard_lock #(
    parameter int NUM_PAGES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [NUM_PAGES-1:0] set_bits,
    output logic [NUM_PAGES-1:0] locked
);

    // bits may only be set; reset is the sole way to clear them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= '0;
        end else if (set_en) begin
            locked <= locked | set_bits;
        end
    end

endmodule

// File: rtl/sram_guard_sweep.sv
module sram_guard_sweep
    import sram_guard_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opt_erase,
    input  logic             start,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    sweep_state_e state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = opt_erase ? ST_SWEEP : ST_IDLE;
            ST_IDLE:  state_d = start ? ST_SWEEP : ST_IDLE;
            ST_SWEEP: state_d = at_last ? ST_IDLE : ST_SWEEP;
            default:  state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        busy  = 1'b1;
        wr_en = 1'b0;
        unique case (state_q)
            ST_BOOT:  busy = 1'b1;
            ST_IDLE:  busy = 1'b0;
            ST_SWEEP: wr_en = 1'b1;
            default:  busy = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_SWEEP && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign idx = cnt_q;

endmodule

// File: rtl/sram_guard.sv
module sram_guard
    import sram_guard_pkg::*;
#(
    parameter int PAGE_WORDS = 256,
    parameter int NUM_PAGES  = 8,
    parameter int IDX_W      = $clog2(PAGE_WORDS * NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 opt_parity_en,
    input  logic                 opt_erase_on_reset,
    input  logic                 req,
    input  logic                 we,
    input  logic [IDX_W-1:0]     addr,
    input  logic [3:0]           be,
    input  logic [31:0]          wdata,
    output logic                 host_ready,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rdata,
    input  logic                 cfg_wr,
    input  logic                 cfg_sel,
    input  logic [NUM_PAGES-1:0] cfg_wdata,
    output logic [NUM_PAGES-1:0] wp_status,
    output logic                 erase_busy,
    output logic                 par_err_flag,
    output logic                 nmi_pulse,
    output logic                 brk_out
);

    localparam int DEPTH = PAGE_WORDS * NUM_PAGES;
    localparam int NP_W  = $clog2(NUM_PAGES);

    // sweep engine
    logic             busy;
    logic             sweep_we;
    logic [IDX_W-1:0] sweep_idx;
    logic             ctrl_wr;
    logic             lock_wr;

    assign ctrl_wr = cfg_wr & cfg_sel;
    assign lock_wr = cfg_wr & ~cfg_sel;

    sram_guard_sweep #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .opt_erase (opt_erase_on_reset),
        .start     (ctrl_wr & cfg_wdata[CTL_ERASE]),
        .busy      (busy),
        .wr_en     (sweep_we),
        .idx       (sweep_idx)
    );

    // page locks
    logic [NUM_PAGES-1:0] locks;

    sram_guard_lock #(.NUM_PAGES(NUM_PAGES)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (lock_wr),
        .set_bits (cfg_wdata),
        .locked   (locks)
    );

    // control bits kept in registers
    logic brk_en_q;
    logic inv_par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_en_q  <= 1'b0;
            inv_par_q <= 1'b0;
        end else if (ctrl_wr) begin
            brk_en_q  <= cfg_wdata[CTL_BRK];
            inv_par_q <= cfg_wdata[CTL_INVPAR];
        end
    end

    // host request decode
    logic            accept;
    logic [NP_W-1:0] page;
    logic            page_locked;
    logic            host_wr;

    assign accept      = req & ~busy;
    assign page        = addr[IDX_W-1 -: NP_W];
    assign page_locked = locks[page];
    assign host_wr     = accept & we & ~page_locked;

    // parity generation and checking
    logic [WORD_W-1:0] rd_word;
    logic [LANES-1:0]  gen_par;
    logic [LANES-1:0]  lane_bad;

    sram_guard_parity u_par (
        .wr_data  (wdata),
        .invert   (inv_par_q),
        .rd_word  (rd_word),
        .wr_par   (gen_par),
        .lane_bad (lane_bad)
    );

    // array port mux: the sweep owns the port whenever it runs
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [LANES-1:0]  mem_lanes;
    logic [WORD_W-1:0] mem_word;

    always_comb begin
        if (sweep_we) begin
            mem_we    = 1'b1;
            mem_idx   = sweep_idx;
            mem_lanes = '1;
            mem_word  = '0;
        end else begin
            mem_we    = host_wr;
            mem_idx   = addr;
            mem_lanes = be;
            mem_word  = {gen_par, wdata};
        end
    end

    sram_guard_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk      (clk),
        .wr_en    (mem_we),
        .wr_idx   (mem_idx),
        .wr_lanes (mem_lanes),
        .wr_word  (mem_word),
        .rd_en    (accept & ~we),
        .rd_idx   (addr),
        .rd_word  (rd_word)
    );

    // response stage
    logic             rv_q;
    logic             rwe_q;
    logic             rerr_q;
    logic [LANES-1:0] rbe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv_q   <= 1'b0;
            rwe_q  <= 1'b0;
            rerr_q <= 1'b0;
            rbe_q  <= '0;
        end else begin
            rv_q   <= accept;
            rwe_q  <= we;
            rerr_q <= accept & we & page_locked;
            if (accept) begin
                rbe_q <= be;
            end
        end
    end

    logic par_err;
    assign par_err = rv_q & ~rwe_q & opt_parity_en & (|(lane_bad & rbe_q));

    // sticky flag: a fresh error outranks a clear request
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (par_err) begin
            flag_q <= 1'b1;
        end else if (ctrl_wr && cfg_wdata[CTL_CLRFLAG]) begin
            flag_q <= 1'b0;
        end
    end

    assign host_ready   = ~busy;
    assign erase_busy   = busy;
    assign rsp_valid    = rv_q;
    assign rsp_err      = rerr_q;
    assign rdata        = rd_word[DATA_W-1:0];
    assign wp_status    = locks;
    assign par_err_flag = flag_q;
    assign nmi_pulse    = par_err;
    assign brk_out      = par_err & brk_en_q;

endmodule

// File: rtl/sram_guard_chk.sv
module sram_guard_chk #(
    parameter int NUM_PAGES = 8,
    parameter int IDX_W     = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 opt_parity_en,
    input logic                 req,
    input logic                 we,
    input logic [IDX_W-1:0]     addr,
    input logic                 host_ready,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [NUM_PAGES-1:0] wp_status,
    input logic                 erase_busy,
    input logic                 par_err_flag,
    input logic                 nmi_pulse,
    input logic                 brk_out
);

    localparam int NP_W = $clog2(NUM_PAGES);

    AST_LOCKED_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req && host_ready && we && wp_status[addr[IDX_W-1 -: NP_W]]) |=> rsp_err); // R11

    AST_NMI_ON_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> (rsp_valid && !rsp_err)); // R6

    AST_FLAG_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> par_err_flag); // R7

    AST_BRK_NEEDS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        brk_out |-> nmi_pulse); // R8

    AST_CHECK_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_parity_en |-> !nmi_pulse); // R9

    AST_LOCKS_ONLY_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        ((wp_status & $past(wp_status)) == $past(wp_status))); // R10

    AST_BUSY_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> !rsp_valid); // R12

endmodule

bind sram_guard sram_guard_chk #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .opt_parity_en (opt_parity_en),
    .req           (req),
    .we            (we),
    .addr          (addr),
    .host_ready    (host_ready),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .wp_status     (wp_status),
    .erase_busy    (erase_busy),
    .par_err_flag  (par_err_flag),
    .nmi_pulse     (nmi_pulse),
    .brk_out       (brk_out)
);

// File: tb/tb_sram_guard.sv
module tb_sram_guard;

    localparam int CLK_PERIOD = 10;
    localparam int PW    = 4;
    localparam int NP    = 8;
    localparam int DEPTH = PW * NP;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          opt_parity_en = 1'b1;
    logic          opt_erase_on_reset = 1'b1;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wdata = '0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [NP-1:0] cfg_wdata = '0;
    logic          host_ready, rsp_valid, rsp_err;
    logic [31:0]   rdata;
    logic [NP-1:0] wp_status;
    logic          erase_busy, par_err_flag, nmi_pulse, brk_out;

    sram_guard #(.PAGE_WORDS(PW), .NUM_PAGES(NP)) dut (
        .clk(clk), .rst_n(rst_n), .opt_parity_en(opt_parity_en),
        .opt_erase_on_reset(opt_erase_on_reset), .req(req), .we(we), .addr(addr),
        .be(be), .wdata(wdata), .host_ready(host_ready), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rdata(rdata), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .wp_status(wp_status), .erase_busy(erase_busy),
        .par_err_flag(par_err_flag), .nmi_pulse(nmi_pulse), .brk_out(brk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [31:0]   m_data [DEPTH];
    logic [3:0]    m_par  [DEPTH];
    logic [NP-1:0] m_wp;
    bit            m_flag, m_brk, m_inv;
    int            m_state;   // 0 boot, 1 idle, 2 sweep
    int            m_cnt;
    bit            m_rv, m_rwe, m_rerr;
    logic [31:0]   m_rdat;
    logic [3:0]    m_rpar, m_rbe;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_nmi();
        logic [3:0] bad;
        for (int i = 0; i < 4; i++) bad[i] = (^m_rdat[i*8 +: 8]) ^ m_rpar[i];
        return m_rv && !m_rwe && opt_parity_en && ((bad & m_rbe) != 4'h0);
    endfunction

    task automatic model_edge();
        bit nmi_now, accept, locked;
        int idx;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_wp = '0; m_flag = 0; m_brk = 0; m_inv = 0;
            m_rv = 0; m_rwe = 0; m_rerr = 0;
            return;
        end
        nmi_now = exp_nmi();
        accept  = req && (m_state == 1);
        idx     = int'(addr);
        locked  = m_wp[idx / PW];
        if (accept) begin
            m_rbe = be;
            if (!we) begin
                m_rdat = m_data[idx];
                m_rpar = m_par[idx];
            end else if (!locked) begin
                for (int i = 0; i < 4; i++) begin
                    if (be[i]) begin
                        m_data[idx][i*8 +: 8] = wdata[i*8 +: 8];
                        m_par[idx][i] = (^wdata[i*8 +: 8]) ^ m_inv;
                    end
                end
            end
        end
        case (m_state)
            0: begin m_state = opt_erase_on_reset ? 2 : 1; m_cnt = 0; end
            1: if (cfg_wr && cfg_sel && cfg_wdata[0]) begin m_state = 2; m_cnt = 0; end
            default: begin
                m_data[m_cnt] = '0;
                m_par[m_cnt]  = '0;
                if (m_cnt == DEPTH - 1) m_state = 1;
                else m_cnt++;
            end
        endcase
        if (nmi_now) m_flag = 1;
        else if (cfg_wr && cfg_sel && cfg_wdata[2]) m_flag = 0;
        if (cfg_wr && !cfg_sel) m_wp = m_wp | cfg_wdata;
        if (cfg_wr && cfg_sel) begin m_brk = cfg_wdata[1]; m_inv = cfg_wdata[3]; end
        m_rv = accept; m_rwe = we; m_rerr = accept && we && locked;
    endtask

    task automatic compare();
        bit en = exp_nmi();
        chk(erase_busy == (m_state != 1), "R12", "erase_busy", erase_busy, m_state != 1);
        chk(host_ready == (m_state == 1), "R12", "host_ready", host_ready, m_state == 1);
        chk(wp_status == m_wp, "R10", "wp_status", wp_status, m_wp);
        chk(par_err_flag == m_flag, "R7", "par_err_flag", par_err_flag, m_flag);
        chk(nmi_pulse == en, "R6", "nmi_pulse", nmi_pulse, en);
        chk(brk_out == (en && m_brk), "R8", "brk_out", brk_out, en && m_brk);
        chk(rsp_valid == m_rv, "R2", "rsp_valid", rsp_valid, m_rv);
        chk(rsp_err == m_rerr, "R11", "rsp_err", rsp_err, m_rerr);
        if (m_rv && !m_rwe) chk(rdata == m_rdat, "R2", "rdata", rdata, m_rdat);
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic host_wr(input int a, input logic [3:0] lanes, input logic [31:0] d);
        req = 1; we = 1; addr = AW'(a); be = lanes; wdata = d;
        tick();
        req = 0; we = 0;
    endtask

    task automatic host_rd(input int a, input logic [3:0] lanes);
        req = 1; we = 0; addr = AW'(a); be = lanes;
        tick();
        req = 0;
    endtask

    task automatic cfg(input bit sel, input logic [NP-1:0] d);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_wr = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int busy_cycles;
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_par[i] = '0; end
        m_rdat = '0; m_rpar = '0; m_rbe = '0;
        @(negedge clk);
        tick(); tick(); tick();
        // R1: state while in reset
        chk(erase_busy && !host_ready && wp_status == 0 && !par_err_flag && !nmi_pulse
            && !brk_out && !rsp_valid, "R1", "reset outputs", erase_busy, 1);
        rst_n = 1;
        busy_cycles = 0;
        while (erase_busy && busy_cycles < 200) begin tick(); busy_cycles++; end
        chk(busy_cycles == 1 + DEPTH, "R13", "busy cycles with erase", busy_cycles, 1 + DEPTH);

        // R2 R3: word, byte and half-word writes
        host_wr(0, 4'hF, 32'hA5A5_1234);
        host_rd(0, 4'hF);
        chk(rdata == 32'hA5A5_1234 && !nmi_pulse, "R2", "word readback", rdata, 32'hA5A5_1234);
        host_wr(1, 4'hF, 32'h1122_3344);
        host_wr(1, 4'b0010, 32'h0000_BB00);
        host_wr(1, 4'b1000, 32'hEE00_0000);
        host_rd(1, 4'hF);
        chk(rdata == 32'hEE22_BB44 && !nmi_pulse, "R3", "partial writes", rdata, 32'hEE22_BB44);

        // R4 R5: plant one bad lane
        cfg(1, NP'(8));
        host_wr(2, 4'b0001, 32'h0000_00C3);
        cfg(1, NP'(0));
        host_rd(2, 4'b1110);
        chk(!nmi_pulse, "R5", "unchecked bad lane", nmi_pulse, 0);
        host_rd(2, 4'b0001);
        chk(nmi_pulse && !brk_out, "R4", "bad lane detected", nmi_pulse, 1);
        tick();
        chk(par_err_flag && !nmi_pulse, "R7", "sticky flag set", par_err_flag, 1);

        // R8: break routing
        cfg(1, NP'(2));
        host_rd(2, 4'hF);
        chk(brk_out && nmi_pulse, "R8", "break routed", brk_out, 1);
        tick();
        // R7: clear flag
        cfg(1, NP'(6));
        chk(!par_err_flag, "R7", "flag cleared", par_err_flag, 0);

        // R9: checking disabled
        opt_parity_en = 0;
        host_rd(2, 4'hF);
        chk(!nmi_pulse && rdata == 32'h0000_00C3, "R9", "check disabled", nmi_pulse, 0);
        tick();
        chk(!par_err_flag, "R9", "flag stays clear", par_err_flag, 0);
        opt_parity_en = 1;

        // R10 R11: page lock (page 2 = words 8..11)
        host_wr(8, 4'hF, 32'hCAFE_F00D);
        host_wr(5, 4'hF, 32'h0000_0077);
        cfg(0, NP'(4));
        chk(wp_status == NP'(4), "R10", "lock set", wp_status, 4);
        host_wr(8, 4'hF, 32'hDEAD_BEEF);
        chk(rsp_valid && rsp_err, "R11", "locked write refused", rsp_err, 1);
        host_rd(8, 4'hF);
        chk(!rsp_err && rdata == 32'hCAFE_F00D, "R11", "locked word kept", rdata, 32'hCAFE_F00D);
        cfg(0, NP'(0));
        chk(wp_status == NP'(4), "R10", "zero write no effect", wp_status, 4);
        host_wr(4, 4'hF, 32'h55AA_55AA);
        chk(rsp_valid && !rsp_err, "R11", "unlocked page write", rsp_err, 0);

        // R12: software erase with host traffic during the sweep
        cfg(1, NP'(3));
        busy_cycles = 0;
        req = 1; we = 1; addr = '0; be = 4'hF; wdata = 32'hFFFF_FFFF;
        while (erase_busy && busy_cycles < 200) begin tick(); busy_cycles++; end
        req = 0; we = 0;
        chk(busy_cycles == DEPTH, "R12", "sweep length", busy_cycles, DEPTH);
        host_rd(0, 4'hF);
        chk(rdata == 0 && !nmi_pulse, "R12", "word erased", rdata, 0);
        host_rd(2, 4'hF);
        chk(rdata == 0 && !nmi_pulse, "R12", "parity restored", nmi_pulse, 0);
        host_wr(5, 4'hF, 32'h0000_0077);

        // R13 R1 R10: reset without erase
        rst_n = 0; opt_erase_on_reset = 0;
        tick();
        chk(wp_status == 0 && erase_busy, "R1", "locks cleared by reset", wp_status, 0);
        rst_n = 1;
        busy_cycles = 0;
        while (erase_busy && busy_cycles < 200) begin tick(); busy_cycles++; end
        chk(busy_cycles == 1, "R13", "busy cycles without erase", busy_cycles, 1);
        host_rd(5, 4'hF);
        chk(rdata == 32'h0000_0077, "R13", "array kept", rdata, 32'h77);
        tick();

        done = 1;
        summary();
        $finish;
    end

endmodule